// File: doc/BRIEF.md
# Indexed Configuration Register File with Management Lock

This block holds a small set of processor configuration registers that software reaches through two I/O ports. One port takes a register index, and the other moves data. A write to the index port arms the block. The next access to the data port then reads or writes the selected register. After that access, the index is spent and must be written again. A data-port access that is not armed, or that names an index the block does not implement, is not claimed. It is flagged so the surrounding logic can send it off chip.

Some fields govern the management mode itself:
- the mode enable bit;
- the two memory-routing bits;
- the NMI-enable bit;
- the region size code;
- the lock bit.

When the lock bit is set, code running outside management mode cannot change these fields. The region base address and the general-purpose byte stay writable. The current register contents drive a set of decoded control outputs every cycle.

Top module: `cfg_index_regs`

## Requirements
- R1: The index port sits at I/O address 22h and the data port at 23h. A write to 22h is claimed and records the written byte as the index. A following data access to 23h is claimed, and the access reads or writes the indexed register. A read returns the value on `rd_data` during the access cycle, and a write becomes visible on the outputs from the next cycle.
- R2: A data-port access is claimed only when the last strobed access before it was an index-port write. Cycles with no strobe do not count as accesses. An access that is not claimed asserts `fwd_off`, returns 0 on `rd_data` and changes no register.
- R3: A claimed data access uses up the index. A second data access with no new index write is forwarded off chip.
- R4: Any strobed access to another address invalidates a pending index. This includes a read of the index port, which is itself forwarded off chip.
- R5: Only the indices C1h, C2h, C3h, CDh, CEh and CFh are implemented. A data access to any other index, such as C4h, is forwarded off chip.
- R6: In C1h, bit 1 is the mode enable, bit 2 the management-region access bit and bit 3 the main-memory access bit. In C3h, bit 0 is the lock bit and bit 1 the NMI enable. The region base `rgn_base[19:0]` carries address bits 31 to 12: CDh gives the top byte, CEh the next byte and CFh bits 7:4 the low nibble. CFh bits 3:0 hold the size code. C2h is eight plain storage bits.
- R7: While the lock bit is 1 and `in_mgmt` is 0, the block ignores writes to the following fields:
  - the three C1h bits;
  - the NMI enable;
  - the lock bit;
  - the size code.

  The access is still claimed. In that state, the base fields and C2h still take writes. With `in_mgmt` at 1, every field is writable.
- R8: Reserved bits (C1h bits 7:4 and 0, C3h bits 7:2) read as 0, and writes to them are discarded.
- R9: Full reset (`rst_n` low) clears every register bit and the pending index. A one-cycle `warm_rst` clears only the pending index and leaves all register contents unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Full reset, active low, asynchronous |
| warm_rst | input | 1 | Warm reset, drops a pending index only |
| io_addr | input | 16 | I/O address of the current access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| in_mgmt | input | 1 | High while the processor runs in management mode |
| rd_data | output | 8 | Read data of a claimed data-port read, else 0 |
| claim | output | 1 | Access is served by this block |
| fwd_off | output | 1 | Access to 22h or 23h must be sent off chip |
| ctl_en | output | 1 | Mode enable (C1h bit 1) |
| ctl_mgmt_acc | output | 1 | Management-region access bit (C1h bit 2) |
| ctl_main_acc | output | 1 | Main-memory access bit (C1h bit 3) |
| ctl_nmi_en | output | 1 | NMI enable (C3h bit 1) |
| ctl_lock | output | 1 | Lock bit (C3h bit 0) |
| rgn_base | output | 20 | Region base, address bits 31 to 12 |
| rgn_size | output | 4 | Region size code |

## Verification
The hardest situation to reach is a pending index that is silently lost. Three things can drop it: an access to an unrelated port, a read of the index port itself, or a warm reset that falls between the index write and the data access. The stimulus sets up each of these explicitly. It writes the index, inserts the disturbing event, and then issues the data access, expecting it to be forwarded. It then reads the target register back through a fresh index to show that nothing changed. The locked case needs the lock bit set from outside management mode first. The bench then writes every protected field with inverted values and reads them back, before it raises `in_mgmt` and shows the same writes take effect.

// File: rtl/cfg_index_regs.sv
module cfg_index_regs #(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] IDX_PORT = 16'h0022,
  parameter logic [15:0] DAT_PORT = 16'h0023
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              warm_rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [7:0]        io_wdata,
  input  logic              in_mgmt,
  output logic [7:0]        rd_data,
  output logic              claim,
  output logic              fwd_off,
  output logic              ctl_en,
  output logic              ctl_mgmt_acc,
  output logic              ctl_main_acc,
  output logic              ctl_nmi_en,
  output logic              ctl_lock,
  output logic [19:0]       rgn_base,
  output logic [3:0]        rgn_size
);
  localparam logic [7:0] IX_CTL  = 8'hC1;
  localparam logic [7:0] IX_AUX  = 8'hC2;
  localparam logic [7:0] IX_SEC  = 8'hC3;
  localparam logic [7:0] IX_BHI  = 8'hCD;
  localparam logic [7:0] IX_BMID = 8'hCE;
  localparam logic [7:0] IX_BLO  = 8'hCF;

  logic       armed_q;
  logic [7:0] idx_q;
  logic       en_q, macc_q, mmac_q, nmi_q, lock_q;
  logic [7:0] aux_q, bhi_q, bmid_q;
  logic [3:0] blo_q, size_q;

  wire acc     = io_rd | io_wr;
  wire idx_hit = (io_addr == IDX_PORT[ADDR_W-1:0]);
  wire dat_hit = (io_addr == DAT_PORT[ADDR_W-1:0]);
  wire known   = (idx_q == IX_CTL) || (idx_q == IX_AUX) || (idx_q == IX_SEC) ||
                 (idx_q == IX_BHI) || (idx_q == IX_BMID) || (idx_q == IX_BLO);
  wire dat_ok  = dat_hit & acc & armed_q & known;
  wire wr_ok   = dat_ok & io_wr;
  wire locked  = lock_q & ~in_mgmt;

  assign claim   = (idx_hit & io_wr) | dat_ok;
  assign fwd_off = acc & (idx_hit | dat_hit) & ~claim;

  always_comb begin
    rd_data = 8'h00;
    if (dat_ok && io_rd) begin
      case (idx_q)
        IX_CTL:  rd_data = {4'h0, mmac_q, macc_q, en_q, 1'b0};
        IX_AUX:  rd_data = aux_q;
        IX_SEC:  rd_data = {6'h00, nmi_q, lock_q};
        IX_BHI:  rd_data = bhi_q;
        IX_BMID: rd_data = bmid_q;
        IX_BLO:  rd_data = {blo_q, size_q};
        default: rd_data = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      idx_q   <= 8'h00;
    end else if (warm_rst) begin
      armed_q <= 1'b0;
    end else if (acc) begin
      armed_q <= idx_hit & io_wr;
      if (idx_hit && io_wr) idx_q <= io_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {en_q, macc_q, mmac_q, nmi_q, lock_q} <= '0;
      aux_q  <= '0;
      bhi_q  <= '0;
      bmid_q <= '0;
      blo_q  <= '0;
      size_q <= '0;
    end else if (wr_ok) begin
      case (idx_q)
        IX_CTL:  if (!locked) {mmac_q, macc_q, en_q} <= io_wdata[3:1];
        IX_AUX:  aux_q <= io_wdata;
        IX_SEC:  if (!locked) {nmi_q, lock_q} <= io_wdata[1:0];
        IX_BHI:  bhi_q  <= io_wdata;
        IX_BMID: bmid_q <= io_wdata;
        IX_BLO: begin
          blo_q <= io_wdata[7:4];
          if (!locked) size_q <= io_wdata[3:0];
        end
        default: ;
      endcase
    end
  end

  assign ctl_en       = en_q;
  assign ctl_mgmt_acc = macc_q;
  assign ctl_main_acc = mmac_q;
  assign ctl_nmi_en   = nmi_q;
  assign ctl_lock     = lock_q;
  assign rgn_base     = {bhi_q, bmid_q, blo_q};
  assign rgn_size     = size_q;

  AST_CLAIM_FWD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(claim && fwd_off)); // R2
  AST_INDEX_SPENT: assert property (@(posedge clk) disable iff (!rst_n)
    (claim && dat_hit) |=> !(claim && dat_hit)); // R3
  AST_LOCK_CTL: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_lock && !in_mgmt && io_wr && dat_hit) |=>
      ($stable(ctl_en) && $stable(ctl_mgmt_acc) && $stable(ctl_main_acc))); // R7
  AST_LOCK_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_lock && !in_mgmt && io_wr && dat_hit) |=>
      ($stable(ctl_nmi_en) && $stable(ctl_lock) && $stable(rgn_size))); // R7
  AST_WARM_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_rst && !io_wr) |=> ($stable(rgn_base) && $stable(rgn_size) && $stable(ctl_en))); // R9
  AST_FWD_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_off |-> (rd_data == 8'h00)); // R2
endmodule

// File: tb/cfg_index_regs_test.sv
module cfg_index_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        warm_rst = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic        in_mgmt = 1'b0;
  logic [7:0]  rd_data;
  logic        claim, fwd_off;
  logic        ctl_en, ctl_mgmt_acc, ctl_main_acc, ctl_nmi_en, ctl_lock;
  logic [19:0] rgn_base;
  logic [3:0]  rgn_size;

  int checks = 0;
  int fails  = 0;
  logic [7:0] rv;
  logic       rc, rf;

  always #2.5 clk = ~clk;

  cfg_index_regs uut (
    .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .io_addr(io_addr),
    .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata), .in_mgmt(in_mgmt),
    .rd_data(rd_data), .claim(claim), .fwd_off(fwd_off),
    .ctl_en(ctl_en), .ctl_mgmt_acc(ctl_mgmt_acc), .ctl_main_acc(ctl_main_acc),
    .ctl_nmi_en(ctl_nmi_en), .ctl_lock(ctl_lock),
    .rgn_base(rgn_base), .rgn_size(rgn_size)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(input logic [15:0] a, input logic r, input logic w,
                        input logic [7:0] d, output logic [7:0] q,
                        output logic c, output logic f);
    @(negedge clk);
    io_addr = a; io_rd = r; io_wr = w; io_wdata = d;
    #1;
    q = rd_data; c = claim; f = fwd_off;
    @(posedge clk);
    #1;
    io_rd = 1'b0; io_wr = 1'b0;
  endtask

  task automatic cfg_wr(input logic [7:0] ix, input logic [7:0] v);
    access(16'h22, 1'b0, 1'b1, ix, rv, rc, rf);
    access(16'h23, 1'b0, 1'b1, v, rv, rc, rf);
  endtask

  task automatic cfg_rd(input logic [7:0] ix, output logic [7:0] v);
    access(16'h22, 1'b0, 1'b1, ix, rv, rc, rf);
    access(16'h23, 1'b1, 1'b0, 8'h00, v, rc, rf);
  endtask

  task automatic test_reset;
    logic [7:0] v;
    check("R9 reset controls", {ctl_en, ctl_mgmt_acc, ctl_main_acc, ctl_nmi_en, ctl_lock}, 0);
    check("R9 reset base", rgn_base, 0);
    check("R9 reset size", rgn_size, 0);
    access(16'h23, 1'b1, 1'b0, 8'h00, v, rc, rf);
    check("R9 reset index invalid", {rc, rf}, 2'b01);
  endtask

  task automatic test_basic;
    logic [7:0] v;
    access(16'h22, 1'b0, 1'b1, 8'hC1, v, rc, rf);
    check("R1 index write claimed", {rc, rf}, 2'b10);
    access(16'h23, 1'b0, 1'b1, 8'hFF, v, rc, rf);
    check("R1 data write claimed", {rc, rf}, 2'b10);
    @(negedge clk);
    check("R6 C1 decode", {ctl_main_acc, ctl_mgmt_acc, ctl_en}, 3'b111);
    cfg_rd(8'hC1, v);
    check("R8 C1 reserved read 0", v, 8'h0E);
    check("R1 data read claimed", rc, 1);
    cfg_wr(8'hC1, 8'h04);
    @(negedge clk);
    check("R6 C1 only mgmt access", {ctl_main_acc, ctl_mgmt_acc, ctl_en}, 3'b010);
    cfg_wr(8'hC3, 8'hFE);
    cfg_rd(8'hC3, v);
    check("R8 C3 reserved read 0", v, 8'h02);
    check("R6 C3 nmi/lock", {ctl_nmi_en, ctl_lock}, 2'b10);
    cfg_wr(8'hCD, 8'hAB);
    cfg_wr(8'hCE, 8'hCD);
    cfg_wr(8'hCF, 8'h57);
    @(negedge clk);
    check("R6 base", rgn_base, 20'hABCD5);
    check("R6 size", rgn_size, 4'h7);
    cfg_wr(8'hC2, 8'h3C);
    cfg_rd(8'hC2, v);
    check("R6 C2 storage", v, 8'h3C);
  endtask

  task automatic test_sequence;
    logic [7:0] v;
    access(16'h23, 1'b0, 1'b1, 8'hFF, v, rc, rf);
    check("R2 unarmed data write forwarded", {rc, rf}, 2'b01);
    cfg_rd(8'hC1, v);
    check("R2 unarmed write no effect", v, 8'h04);
    access(16'h22, 1'b0, 1'b1, 8'hCD, v, rc, rf);
    repeat (3) @(negedge clk);
    access(16'h23, 1'b1, 1'b0, 8'h00, v, rc, rf);
    check("R2 idle cycles keep index", v, 8'hAB);
    access(16'h23, 1'b1, 1'b0, 8'h00, v, rc, rf);
    check("R3 second data read forwarded", {rc, rf}, 2'b01);
    check("R2 forwarded read data 0", v, 8'h00);
    access(16'h22, 1'b0, 1'b1, 8'hCD, v, rc, rf);
    access(16'h80, 1'b0, 1'b1, 8'h11, v, rc, rf);
    check("R4 other port not claimed", {rc, rf}, 2'b00);
    access(16'h23, 1'b0, 1'b1, 8'h00, v, rc, rf);
    check("R4 other port invalidates", {rc, rf}, 2'b01);
    access(16'h22, 1'b0, 1'b1, 8'hCD, v, rc, rf);
    access(16'h22, 1'b1, 1'b0, 8'h00, v, rc, rf);
    check("R4 index read forwarded", {rc, rf}, 2'b01);
    access(16'h23, 1'b0, 1'b1, 8'h00, v, rc, rf);
    check("R4 index read invalidates", {rc, rf}, 2'b01);
    @(negedge clk);
    check("R4 base unchanged", rgn_base, 20'hABCD5);
    access(16'h22, 1'b0, 1'b1, 8'hC4, v, rc, rf);
    access(16'h23, 1'b0, 1'b1, 8'h55, v, rc, rf);
    check("R5 unknown index forwarded", {rc, rf}, 2'b01);
  endtask

  task automatic test_lock;
    logic [7:0] v;
    in_mgmt = 1'b0;
    cfg_wr(8'hC1, 8'h0E);
    cfg_wr(8'hC3, 8'h01);
    @(negedge clk);
    check("R6 lock set", {ctl_nmi_en, ctl_lock}, 2'b01);
    access(16'h22, 1'b0, 1'b1, 8'hC1, v, rc, rf);
    access(16'h23, 1'b0, 1'b1, 8'h00, v, rc, rf);
    check("R7 locked write still claimed", rc, 1);
    cfg_rd(8'hC1, v);
    check("R7 locked C1 unchanged", v, 8'h0E);
    cfg_wr(8'hC3, 8'h02);
    cfg_rd(8'hC3, v);
    check("R7 locked C3 unchanged", v, 8'h01);
    cfg_wr(8'hCF, 8'h90);
    cfg_rd(8'hCF, v);
    check("R7 locked base nibble writes, size kept", v, 8'h97);
    cfg_wr(8'hC2, 8'h5A);
    cfg_rd(8'hC2, v);
    check("R7 locked C2 writable", v, 8'h5A);
    in_mgmt = 1'b1;
    cfg_wr(8'hC1, 8'h00);
    cfg_wr(8'hCF, 8'h93);
    @(negedge clk);
    check("R7 mgmt C1 write", {ctl_main_acc, ctl_mgmt_acc, ctl_en}, 3'b000);
    check("R7 mgmt size write", rgn_size, 4'h3);
    cfg_wr(8'hC3, 8'h00);
    @(negedge clk);
    check("R7 mgmt unlock", ctl_lock, 0);
    in_mgmt = 1'b0;
  endtask

  task automatic test_warm;
    logic [7:0] v;
    cfg_wr(8'hC1, 8'h02);
    access(16'h22, 1'b0, 1'b1, 8'hCE, v, rc, rf);
    @(negedge clk); warm_rst = 1'b1;
    @(negedge clk); warm_rst = 1'b0;
    access(16'h23, 1'b0, 1'b1, 8'h00, v, rc, rf);
    check("R9 warm reset drops index", {rc, rf}, 2'b01);
    @(negedge clk);
    check("R9 warm reset keeps base", rgn_base, 20'hABCD9);
    check("R9 warm reset keeps enable", ctl_en, 1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R9 full reset clears base", rgn_base, 0);
    check("R9 full reset clears controls", {ctl_en, ctl_lock, rgn_size}, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_basic();
    test_sequence();
    test_lock();
    test_warm();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule